// File: doc/BRIEF.md
# EDO DRAM Data Pin Output Control

This block is a device-side model of the part of an EDO DRAM that decides what the four data pins do. It watches the active-low row strobe, column strobe, write enable and output enable, and decides on each clock whether the pins drive read data, float, or take write data. It also decides whether a write is actually committed to storage. A small internal array stands in for the real cell array. Row and column addresses share one address bus, and the array index is the row in the upper bits and the column in the lower bits.

The pins are asynchronous, so every strobe, the address and the write data first pass through two clocked sampling stages. Edges are then found between the sampled value and its previous value, and one state register acts on them. Analog turn-off delays become clocked events. Any change at the inputs therefore shows at the outputs on the third rising clock edge after it is applied.

The output state depends on the order of the strobe edges and on output-enable pulses. It is not a plain tristate gated by output enable. Read data stays on the pins after the column strobe returns high, which is the extended-data-out behaviour.

Top module: `edo_dq_ctrl`

## Requirements
- R1: After reset, `dq_oe` and `wr_commit` are 0.
- R2: A column strobe fall with the row strobe low and write enable high starts a read. `dq_out` shows the array word at index {row, col}. The row is taken at the row strobe fall and the column at the column strobe fall. While output enable is low, `dq_oe` is 1. This also holds for each further column strobe fall in the same row cycle (page access).
- R3: After a read, a column strobe rise leaves the pins driven with unchanged data, as long as the row strobe and output enable stay low.
- R4: While output enable is sampled high, `dq_oe` is 0. While the column strobe is low, raising and then lowering output enable turns the pins off and then back on with the same data.
- R5: An output enable rise while the column strobe is high and the row strobe is low turns the pins off. They stay off after output enable falls again, until the next read column strobe fall.
- R6: Write enable low at the column strobe fall is an early write. This includes write enable falling in the same sampled cycle as the column strobe. It gives exactly one `wr_commit` pulse carrying {row, col} and the write data. The pins are not driven during that column cycle, even with output enable low.
- R7: Write enable falling while the column strobe is low after a read, with output enable high, is a late write. It commits the address and data present at that write enable fall. The pins stay off for the rest of that column cycle, even if output enable falls, and the written word is read back later.
- R8: Write enable falling during a read while output enable is low commits nothing. The pins keep driving the read data.
- R9: Write enable falling while the column strobe is high turns the pins off. They stay off until the column strobe falls again with write enable high.
- R10: Once both the row strobe and the column strobe are high, after whichever of the two rose last, `dq_oe` is 0 regardless of output enable. If the row strobe rises while the column strobe is still low, the pins stay on.
- R11: If the column strobe is already low when the row strobe falls, the cycle is a refresh. The pins keep their previous drive state and data, and no new row or column is taken.
- R12: An input change shows at the outputs on the third rising clock edge after it is applied, and not on the second.
- R13: `wr_commit` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Write data from the pins |
| dq_oe | output | 1 | Pin driver enable |
| dq_out | output | DW | Read data toward the pins |
| wr_commit | output | 1 | One-cycle strobe: a write is committed |
| wr_addr | output | 2*AW | Committed array index {row, col} |
| wr_data | output | DW | Committed write data |

## Verification
The write-enable fall and the column-strobe fall can land in the same sampled cycle. The block must then choose between an early write and a read that is later turned into a late write. The bench drives both strobes on the same clock phase, and it also covers the case where write enable leads by several cycles. In both cases the result is judged by exactly one commit pulse with the right address and data, and by the pins never being driven while the column strobe is low.

// File: rtl/edo_dq_ctrl.sv
module edo_dq_ctrl #(
  parameter int DW = 4,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   din,
  output logic            dq_oe,
  output logic [DW-1:0]   dq_out,
  output logic            wr_commit,
  output logic [2*AW-1:0] wr_addr,
  output logic [DW-1:0]   wr_data
);
  localparam int MAW   = 2 * AW;
  localparam int DEPTH = 1 << MAW;
  localparam int P_RAS = 3;
  localparam int P_CAS = 2;
  localparam int P_WE  = 1;
  localparam int P_OE  = 0;

  logic [3:0]    s1, s2, pv;
  logic [AW-1:0] a1, a2;
  logic [DW-1:0] d1, d2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1; s2 <= '1; pv <= '1;
      a1 <= '0; a2 <= '0; d1 <= '0; d2 <= '0;
    end else begin
      s1 <= {ras_n, cas_n, we_n, oe_n};
      s2 <= s1;
      pv <= s2;
      a1 <= addr; a2 <= a1;
      d1 <= din;  d2 <= d1;
    end
  end

  logic [3:0] fall, rise, low;
  assign fall = pv & ~s2;
  assign rise = ~pv & s2;
  assign low  = ~s2;

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  row_q, row_n;
  logic           hold_q, hold_n;
  logic           rd_q, rd_n;
  logic           cbr_q, cbr_n;
  logic [DW-1:0]  dout_q, dout_n;
  logic           cmt_n;
  logic [MAW-1:0] wa_n;
  logic [DW-1:0]  wd_n;

  always_comb begin
    row_n  = row_q;
    hold_n = hold_q;
    rd_n   = rd_q;
    cbr_n  = cbr_q;
    dout_n = dout_q;
    cmt_n  = 1'b0;
    wa_n   = wr_addr;
    wd_n   = wr_data;

    if (rise[P_RAS]) cbr_n = 1'b0;
    if (fall[P_RAS]) begin
      if (low[P_CAS]) cbr_n = 1'b1;
      else            row_n = a2;
    end
    if (rise[P_CAS]) rd_n = 1'b0;
    if ((rise[P_RAS] || rise[P_CAS]) && !low[P_RAS] && !low[P_CAS])
      hold_n = 1'b0;
    if (rise[P_OE] && !low[P_CAS] && low[P_RAS])
      hold_n = 1'b0;
    if (fall[P_WE] && !low[P_CAS])
      hold_n = 1'b0;
    if (fall[P_WE] && low[P_CAS] && low[P_RAS] && rd_q && !low[P_OE]) begin
      cmt_n  = 1'b1;
      wa_n   = {row_q, wr_addr[AW-1:0]};
      wd_n   = d2;
      hold_n = 1'b0;
      rd_n   = 1'b0;
    end
    if (fall[P_CAS] && low[P_RAS] && !fall[P_RAS] && !cbr_q) begin
      if (low[P_WE]) begin
        cmt_n  = 1'b1;
        wa_n   = {row_q, a2};
        wd_n   = d2;
        hold_n = 1'b0;
        rd_n   = 1'b0;
      end else begin
        wa_n   = {row_q, a2};
        dout_n = mem[{row_q, a2}];
        hold_n = 1'b1;
        rd_n   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q     <= '0;
      hold_q    <= 1'b0;
      rd_q      <= 1'b0;
      cbr_q     <= 1'b0;
      dout_q    <= '0;
      wr_commit <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      row_q     <= row_n;
      hold_q    <= hold_n;
      rd_q      <= rd_n;
      cbr_q     <= cbr_n;
      dout_q    <= dout_n;
      wr_commit <= cmt_n;
      wr_addr   <= wa_n;
      wr_data   <= wd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (cmt_n) begin
      mem[wa_n] <= wd_n;
    end
  end

  assign dq_oe  = hold_q & ~pv[P_OE];
  assign dq_out = dout_q;
endmodule

// File: rtl/edo_dq_ctrl_chk.sv
module edo_dq_ctrl_chk #(
  parameter int DW = 4,
  parameter int AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            oe_n,
  input logic            dq_oe,
  input logic            wr_commit,
  input logic [2*AW-1:0] wr_addr,
  input logic [DW-1:0]   wr_data
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R13
  AST_IDLE_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(ras_n, 3) && $past(cas_n, 3)) |-> !dq_oe); // R10
  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && $past(oe_n, 3)) |-> !dq_oe); // R4
  AST_COMMIT_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && wr_commit) |-> !$past(we_n, 3)); // R6
  AST_NO_COMMIT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !dq_oe); // R8
endmodule

bind edo_dq_ctrl edo_dq_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .wr_commit(wr_commit), .wr_addr(wr_addr),
  .wr_data(wr_data)
);

// File: tb/edo_dq_ctrl_bench.sv
module edo_dq_ctrl_bench;
  localparam int DW = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic dq_oe, wr_commit;
  logic [DW-1:0] dq_out, wr_data;
  logic [2*AW-1:0] wr_addr;

  edo_dq_ctrl #(.DW(DW), .AW(AW)) u_edo_dq_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_oe(dq_oe), .dq_out(dq_out),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, n_commit = 0;
  logic [2*AW-1:0] last_addr = '0;
  logic [DW-1:0]   last_data = '0;
  logic [DW-1:0]   ref_mem [1 << (2*AW)];
  bit done = 0;

  always @(negedge clk) if (wr_commit) begin
    n_commit++;
    last_addr = wr_addr;
    last_data = wr_data;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic close_cycle();
    @(negedge clk); cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    settle();
    @(negedge clk); ras_n = 1'b1;
    settle();
    check(dq_oe == 1'b0, "R10 closed", dq_oe, 0);
  endtask

  task automatic t_reset();
    check(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
    check(wr_commit == 1'b0, "R1 wr_commit", wr_commit, 0);
  endtask

  task automatic t_early_write(input int row, input int col, input int data, input bit same);
    int n0;
    bit drv = 0;
    @(negedge clk); addr = AW'(row); ras_n = 1'b0; oe_n = 1'b0;
    settle();
    n0 = n_commit;
    if (!same) begin
      @(negedge clk); we_n = 1'b0;
      settle();
    end
    @(negedge clk); addr = AW'(col); din = DW'(data); cas_n = 1'b0; we_n = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (dq_oe) drv = 1;
    end
    check(n_commit == n0 + 1, "R6 one commit", n_commit - n0, 1);
    check(last_addr == (2*AW)'(row * (1 << AW) + col), "R6 address", last_addr, row * (1 << AW) + col);
    check(last_data == DW'(data), "R6 data", last_data, data);
    check(drv == 0, "R6 no drive", drv, 0);
    ref_mem[row * (1 << AW) + col] = DW'(data);
    close_cycle();
  endtask

  task automatic t_read_open(input int row, input int col);
    @(negedge clk); addr = AW'(row); ras_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    settle();
    @(negedge clk); addr = AW'(col); cas_n = 1'b0;
    repeat (2) @(negedge clk);
    check(dq_oe == 1'b0, "R12 not yet", dq_oe, 0);
    @(negedge clk);
    check(dq_oe == 1'b1, "R12 on third edge", dq_oe, 1);
    check(dq_out == ref_mem[row * (1 << AW) + col], "R2 read data", dq_out, ref_mem[row * (1 << AW) + col]);
    @(negedge clk);
  endtask

  task automatic t_edo_oe();
    t_read_open(1, 2);
    @(negedge clk); oe_n = 1'b1; settle();
    check(dq_oe == 1'b0, "R4 oe high off", dq_oe, 0);
    @(negedge clk); oe_n = 1'b0; settle();
    check(dq_oe == 1'b1 && dq_out == ref_mem[10], "R4 oe low on", dq_out, ref_mem[10]);
    @(negedge clk); cas_n = 1'b1; settle();
    check(dq_oe == 1'b1 && dq_out == ref_mem[10], "R3 edo hold", {dq_oe, dq_out}, {1'b1, ref_mem[10]});
    @(negedge clk); oe_n = 1'b1; settle();
    @(negedge clk); oe_n = 1'b0; settle();
    check(dq_oe == 1'b0, "R5 oe pulse off", dq_oe, 0);
    @(negedge clk); addr = 3'd5; cas_n = 1'b0; settle();
    check(dq_oe == 1'b1 && dq_out == ref_mem[13], "R2 page read", dq_out, ref_mem[13]);
    close_cycle();
  endtask

  task automatic t_we_disable();
    t_read_open(6, 3);
    @(negedge clk); cas_n = 1'b1; settle();
    @(negedge clk); we_n = 1'b0; settle();
    check(dq_oe == 1'b0, "R9 we fall off", dq_oe, 0);
    @(negedge clk); we_n = 1'b1; settle();
    check(dq_oe == 1'b0, "R9 stays off", dq_oe, 0);
    @(negedge clk); addr = 3'd3; cas_n = 1'b0; settle();
    check(dq_oe == 1'b1 && dq_out == ref_mem[51], "R9 next read on", dq_out, ref_mem[51]);
    close_cycle();
  endtask

  task automatic t_late_write();
    int n0;
    t_read_open(0, 0);
    n0 = n_commit;
    @(negedge clk); din = 4'h3; we_n = 1'b0; settle();
    check(n_commit == n0, "R8 no commit", n_commit - n0, 0);
    check(dq_oe == 1'b1 && dq_out == ref_mem[0], "R8 still driving", dq_out, ref_mem[0]);
    @(negedge clk); we_n = 1'b1; settle();
    @(negedge clk); oe_n = 1'b1; settle();
    @(negedge clk); din = 4'h6; we_n = 1'b0; settle();
    check(n_commit == n0 + 1, "R7 one commit", n_commit - n0, 1);
    check(last_addr == 0 && last_data == 4'h6, "R7 addr/data", {last_addr, last_data}, 6);
    ref_mem[0] = 4'h6;
    @(negedge clk); oe_n = 1'b0; settle();
    check(dq_oe == 1'b0, "R7 pins off", dq_oe, 0);
    close_cycle();
    t_read_open(0, 0);
    check(dq_out == 4'h6, "R7 read back", dq_out, 6);
    close_cycle();
  endtask

  task automatic t_turn_off();
    t_read_open(1, 5);
    @(negedge clk); ras_n = 1'b1; settle();
    check(dq_oe == 1'b1, "R10 ras first stays on", dq_oe, 1);
    @(negedge clk); cas_n = 1'b1; settle();
    check(dq_oe == 1'b0, "R10 cas last off", dq_oe, 0);
    t_read_open(1, 5);
    @(negedge clk); cas_n = 1'b1; settle();
    check(dq_oe == 1'b1, "R10 cas first stays on", dq_oe, 1);
    @(negedge clk); ras_n = 1'b1; settle();
    check(dq_oe == 1'b0, "R10 ras last off", dq_oe, 0);
  endtask

  task automatic t_refresh();
    t_read_open(6, 3);
    @(negedge clk); ras_n = 1'b1; settle();
    @(negedge clk); addr = 3'd1; ras_n = 1'b0; settle();
    check(dq_oe == 1'b1 && dq_out == ref_mem[51], "R11 kept", dq_out, ref_mem[51]);
    @(negedge clk); cas_n = 1'b1; settle();
    check(dq_oe == 1'b1 && dq_out == ref_mem[51], "R11 after cas rise", dq_out, ref_mem[51]);
    @(negedge clk); ras_n = 1'b1; settle();
    check(dq_oe == 1'b0, "R10 after refresh", dq_oe, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << (2*AW)); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    settle();
    t_reset();
    t_early_write(1, 2, 4'hA, 1'b1);
    t_early_write(1, 5, 4'h5, 1'b0);
    t_early_write(6, 3, 4'hC, 1'b1);
    t_early_write(0, 0, 4'h9, 1'b0);
    t_edo_oe();
    t_we_disable();
    t_late_write();
    t_turn_off();
    t_refresh();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule